// File: doc/BRIEF.md
# Frame Writeback Sequencer

This block sequences the write of one composited video frame into a raster buffer in memory. Software programs a base address, a line stride and the frame size through five 32-bit registers, then issues a start command. While the frame runs, the block accepts a stream of 32-bit pixel words, each tagged with an end-of-line marker. For every accepted word it issues one write request carrying an address, the word and a byte-strobe mask.

A single output register stage holds each write request until the memory side accepts it. A line counts as committed when the write of its final word has been accepted. The block reports a busy flag and a readable count of committed lines. An abort command ends the frame at once and drops any pending write. When the block goes idle it can raise an interrupt, which software acknowledges by clearing the enable bit.

Top module: `frame_writeback_dma`

## Requirements
- R1: The register offsets are decoded on `busAddr` as follows.
  - 0x00 holds the destination pointer; its bits 1:0 always read 0.
  - 0x04 holds the line pitch; its bits 3:0 always read 0.
  - 0x08 holds the frame size, with width in bits 15:0 and height in bits 31:16.
  - 0x10 reads the progress count and ignores writes.
- R2: The control word at 0x0C reads back as follows.
  - Bits 31:24 read 0x54 and bits 23:22 read 01.
  - Bit 21 is a stored power-down flag, bits 19:16 are a stored byte-enable mask and bit 2 is the stored interrupt enable.
  - Bit 1 is the busy flag; bit 0 and all other bits read 0.
- R3: A control write with bit 0 set while idle does three things.
  - Busy reads 1 from the next cycle.
  - Pointer, pitch, height and the written byte-enable mask are latched for the frame.
  - The same write while busy is ignored: later register writes and the go bit do not disturb the running frame.
- R4: The write for word k of line n goes to `pointer + n*pitch + 4*k`, carries the pixel word unchanged, and has `memWrStrb` equal to the latched byte-enable mask.
- R5: A write request with `memWrValid` high and `memWrReady` low keeps the same address and data on the next cycle.
- R6: Progress counts the lines whose end-of-line word write has been accepted. It is cleared to 0 by an accepted go.
- R7: Once height lines have been taken in, `pixReady` stays low. Busy clears on the cycle after the last line is committed.
- R8: A control write with bit 14 set while busy does two things on the next cycle: it drops `memWrValid` and clears busy. Progress keeps its value.
- R9: `irq` is high when a frame has ended and the enable in control bit 2 is set. Writing that bit to 0 drops `irq`. An accepted go clears the ended state.
- R10: A frame of height 0 holds busy for exactly one cycle and then ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busWrEn | input | 1 | Register write strobe |
| busAddr | input | 5 | Register byte offset |
| busWrData | input | 32 | Register write data |
| busRdData | output | 32 | Register read data for `busAddr` (combinational) |
| pixValid | input | 1 | Pixel word valid |
| pixData | input | 32 | Pixel word |
| pixEol | input | 1 | Marks the last word of a line |
| pixReady | output | 1 | Pixel word accepted when high with `pixValid` |
| memWrValid | output | 1 | Write request valid |
| memWrAddr | output | 32 | Write byte address |
| memWrData | output | 32 | Write data |
| memWrStrb | output | 4 | Write byte strobes |
| memWrReady | input | 1 | Memory accepts the write request |
| irq | output | 1 | Idle interrupt |

## Verification
The bench stalls the memory side in an alternating pattern. A design that let the output register be overwritten would change the address during a stall or skip a word. The bench also writes a new pointer and a second go in the middle of a frame. A design that did not latch its settings, or that restarted, would produce addresses from the new base or reset the progress count.

The exact cycles of busy, progress and interrupt around the final write are checked. This catches a design that ends at the last accept rather than the last commit. An abort issued with a write stalled must remove the request and leave progress at zero. A zero-height frame must end on its own rather than hang busy.

// File: rtl/fwb_pkg.sv
package fwb_pkg;
  localparam int REG_AW = 5;
  localparam int STRB_W = 4;

  localparam logic [REG_AW-1:0] OFS_PTR   = 5'h00;
  localparam logic [REG_AW-1:0] OFS_PITCH = 5'h04;
  localparam logic [REG_AW-1:0] OFS_DIM   = 5'h08;
  localparam logic [REG_AW-1:0] OFS_CTRL  = 5'h0C;
  localparam logic [REG_AW-1:0] OFS_PROG  = 5'h10;

  localparam int BIT_GO    = 0;
  localparam int BIT_IRQEN = 2;
  localparam int BIT_ABORT = 14;
  localparam int BE_LSB    = 16;
  localparam int BIT_PWRDN = 21;

  localparam logic [7:0] ID_TAG  = 8'h54;
  localparam logic [1:0] REV_TAG = 2'b01;

  typedef struct packed {
    logic              start;
    logic              kill;
    logic [STRB_W-1:0] byteEn;
  } ctrlStrobe_t;
endpackage

// File: rtl/fwb_ctrl.sv
module fwb_ctrl import fwb_pkg::*; #(
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              frameDone,
  input  logic [LINE_W-1:0] linesDone,
  output ctrlStrobe_t       strobes,
  output logic [31:0]       dstPtr,
  output logic [31:0]       dstPitch,
  output logic [LINE_W-1:0] frameHeight,
  output logic              busy,
  output logic              irq
);
  logic [31:0] ptrQ, pitchQ, dimQ;
  logic [STRB_W-1:0] beQ;
  logic eiQ, pdQ, busyQ, doneQ;

  logic wrCtrl, goAcc, abortAcc;
  assign wrCtrl   = busWrEn && (busAddr == OFS_CTRL);
  assign goAcc    = wrCtrl && busWrData[BIT_GO] && !busyQ;
  assign abortAcc = wrCtrl && busWrData[BIT_ABORT] && busyQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ptrQ   <= '0;
      pitchQ <= '0;
      dimQ   <= '0;
      beQ    <= '0;
      eiQ    <= 1'b0;
      pdQ    <= 1'b0;
      busyQ  <= 1'b0;
      doneQ  <= 1'b0;
    end else begin
      if (busWrEn && busAddr == OFS_PTR)   ptrQ   <= busWrData & ~32'h3;
      if (busWrEn && busAddr == OFS_PITCH) pitchQ <= busWrData & ~32'hF;
      if (busWrEn && busAddr == OFS_DIM)   dimQ   <= busWrData;
      if (wrCtrl) begin
        eiQ <= busWrData[BIT_IRQEN];
        pdQ <= busWrData[BIT_PWRDN];
        beQ <= busWrData[BE_LSB +: STRB_W];
      end
      if (goAcc)                         busyQ <= 1'b1;
      else if (abortAcc || frameDone)    busyQ <= 1'b0;
      if (goAcc)                              doneQ <= 1'b0;
      else if (busyQ && (abortAcc || frameDone)) doneQ <= 1'b1;
    end
  end

  assign strobes.start  = goAcc;
  assign strobes.kill   = abortAcc;
  assign strobes.byteEn = busWrData[BE_LSB +: STRB_W];
  assign dstPtr      = ptrQ;
  assign dstPitch    = pitchQ;
  assign frameHeight = dimQ[16 +: LINE_W];
  assign busy        = busyQ;
  assign irq         = doneQ && eiQ;

  always_comb begin
    case (busAddr)
      OFS_PTR:   busRdData = ptrQ;
      OFS_PITCH: busRdData = pitchQ;
      OFS_DIM:   busRdData = dimQ;
      OFS_CTRL:  busRdData = {ID_TAG, REV_TAG, pdQ, 1'b0, beQ, 13'b0, eiQ, busyQ, 1'b0};
      OFS_PROG:  busRdData = {{(32-LINE_W){1'b0}}, linesDone};
      default:   busRdData = '0;
    endcase
  end

  AST_GO_SETS_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && busWrData[BIT_GO] && !busyQ) |=> busyQ); // R3
  AST_ABORT_IDLES: assert property (@(posedge clk) disable iff (!rstN)
    (wrCtrl && busWrData[BIT_ABORT] && busyQ) |=> !busyQ); // R8
  AST_IRQ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    irq |-> !busyQ); // R9
endmodule

// File: rtl/fwb_datapath.sv
module fwb_datapath import fwb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobes,
  input  logic              busy,
  input  logic [ADDR_W-1:0] dstPtr,
  input  logic [ADDR_W-1:0] dstPitch,
  input  logic [LINE_W-1:0] frameHeight,
  input  logic              pixValid,
  input  logic [8*STRB_W-1:0] pixData,
  input  logic              pixEol,
  output logic              pixReady,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [8*STRB_W-1:0] memWrData,
  output logic [STRB_W-1:0] memWrStrb,
  input  logic              memWrReady,
  output logic              frameDone,
  output logic [LINE_W-1:0] linesDone
);
  localparam logic [ADDR_W-1:0] WORD_STEP = ADDR_W'(STRB_W);

  logic [ADDR_W-1:0] lineBase, wordOff, pitchQ;
  logic [LINE_W-1:0] issued, committed, heightQ;
  logic [STRB_W-1:0] strbQ;
  logic eolQ;
  logic accept, drain;

  assign pixReady = busy && (issued < heightQ) && (!memWrValid || memWrReady);
  assign accept   = pixValid && pixReady;
  assign drain    = memWrValid && memWrReady;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      lineBase   <= '0;
      wordOff    <= '0;
      pitchQ     <= '0;
      issued     <= '0;
      committed  <= '0;
      heightQ    <= '0;
      strbQ      <= '0;
      eolQ       <= 1'b0;
      memWrValid <= 1'b0;
      memWrAddr  <= '0;
      memWrData  <= '0;
      memWrStrb  <= '0;
    end else if (strobes.start) begin
      lineBase   <= dstPtr;
      pitchQ     <= dstPitch;
      heightQ    <= frameHeight;
      strbQ      <= strobes.byteEn;
      wordOff    <= '0;
      issued     <= '0;
      committed  <= '0;
      memWrValid <= 1'b0;
    end else if (strobes.kill) begin
      memWrValid <= 1'b0;
    end else begin
      if (drain && eolQ) committed <= committed + 1'b1;
      if (accept) begin
        memWrValid <= 1'b1;
        memWrAddr  <= lineBase + wordOff;
        memWrData  <= pixData;
        memWrStrb  <= strbQ;
        eolQ       <= pixEol;
        if (pixEol) begin
          lineBase <= lineBase + pitchQ;
          wordOff  <= '0;
          issued   <= issued + 1'b1;
        end else begin
          wordOff  <= wordOff + WORD_STEP;
        end
      end else if (drain) begin
        memWrValid <= 1'b0;
      end
    end
  end

  assign frameDone = busy && (committed == heightQ);
  assign linesDone = committed;

  AST_HOLD_REQUEST: assert property (@(posedge clk) disable iff (!rstN)
    (memWrValid && !memWrReady && !strobes.kill) |=>
      (memWrValid && $stable(memWrAddr) && $stable(memWrData))); // R5
  AST_NO_WRITE_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !memWrValid); // R8
  AST_PROGRESS_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (committed <= heightQ)); // R6
  AST_WORD_ALIGNED: assert property (@(posedge clk) disable iff (!rstN)
    memWrValid |-> (memWrAddr[1:0] == 2'b00)); // R4
endmodule

// File: rtl/frame_writeback_dma.sv
module frame_writeback_dma import fwb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int LINE_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [REG_AW-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              pixValid,
  input  logic [31:0]       pixData,
  input  logic              pixEol,
  output logic              pixReady,
  output logic              memWrValid,
  output logic [ADDR_W-1:0] memWrAddr,
  output logic [31:0]       memWrData,
  output logic [STRB_W-1:0] memWrStrb,
  input  logic              memWrReady,
  output logic              irq
);
  ctrlStrobe_t strobes;
  logic [31:0] dstPtr, dstPitch;
  logic [LINE_W-1:0] frameHeight, linesDone;
  logic busy, frameDone;

  fwb_ctrl #(.LINE_W(LINE_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .frameDone(frameDone), .linesDone(linesDone),
    .strobes(strobes), .dstPtr(dstPtr), .dstPitch(dstPitch), .frameHeight(frameHeight),
    .busy(busy), .irq(irq)
  );

  fwb_datapath #(.ADDR_W(ADDR_W), .LINE_W(LINE_W)) uData (
    .clk(clk), .rstN(rstN), .strobes(strobes), .busy(busy),
    .dstPtr(dstPtr[ADDR_W-1:0]), .dstPitch(dstPitch[ADDR_W-1:0]), .frameHeight(frameHeight),
    .pixValid(pixValid), .pixData(pixData), .pixEol(pixEol), .pixReady(pixReady),
    .memWrValid(memWrValid), .memWrAddr(memWrAddr), .memWrData(memWrData),
    .memWrStrb(memWrStrb), .memWrReady(memWrReady),
    .frameDone(frameDone), .linesDone(linesDone)
  );
endmodule

// File: tb/tb_frame_writeback_dma.sv
`timescale 1ns/1ps
module tb_frame_writeback_dma;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rstN, busWrEn, pixValid, pixEol, pixReady, memWrValid, memWrReady, irq;
  logic [4:0]  busAddr;
  logic [31:0] busWrData, busRdData, pixData, memWrAddr, memWrData;
  logic [3:0]  memWrStrb;

  frame_writeback_dma dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr), .busWrData(busWrData),
    .busRdData(busRdData), .pixValid(pixValid), .pixData(pixData), .pixEol(pixEol),
    .pixReady(pixReady), .memWrValid(memWrValid), .memWrAddr(memWrAddr),
    .memWrData(memWrData), .memWrStrb(memWrStrb), .memWrReady(memWrReady), .irq(irq)
  );

  int nChk = 0;
  int nBad = 0;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChk++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    busAddr = a;
    #1;
    d = busRdData;
  endtask

  // memory-side model and write checker
  int readyMode = 0;          // 0 always ready, 1 alternating, 2 never
  logic [31:0] expPtr, expPitch;
  int expWords;
  logic [3:0] expStrb;
  int mLine = 0, mWord = 0, wrCount = 0;
  logic stallSeen = 1'b0;
  logic [31:0] stallAddr, stallData;

  always @(negedge clk) begin
    if (readyMode == 0)      memWrReady = 1'b1;
    else if (readyMode == 1) memWrReady = ~memWrReady;
    else                     memWrReady = 1'b0;
    #1;
    if (!memWrValid) stallSeen = 1'b0;
    else begin
      if (stallSeen) begin
        check("R5 stall addr", memWrAddr, stallAddr);
        check("R5 stall data", memWrData, stallData);
      end
      if (memWrReady) begin
        check("R4 addr", memWrAddr, expPtr + mLine * expPitch + 4 * mWord);
        check("R4 data", memWrData, {8'hA5, 12'(mLine), 12'(mWord)});
        check("R4 strb", {28'd0, memWrStrb}, {28'd0, expStrb});
        wrCount++;
        stallSeen = 1'b0;
        if (mWord == expWords - 1) begin mWord = 0; mLine++; end
        else mWord++;
      end else begin
        stallSeen = 1'b1;
        stallAddr = memWrAddr;
        stallData = memWrData;
      end
    end
  end

  task automatic sendLines(input int first, input int nLines, input int words);
    for (int l = first; l < first + nLines; l++) begin
      for (int w = 0; w < words; w++) begin
        @(negedge clk);
        pixValid = 1'b1;
        pixData  = {8'hA5, 12'(l), 12'(w)};
        pixEol   = (w == words - 1);
        #2;
        while (!pixReady) begin @(negedge clk); #2; end
      end
    end
    @(negedge clk);
    pixValid = 1'b0; pixEol = 1'b0;
  endtask

  task automatic setupFrame(input logic [31:0] p, input logic [31:0] pt, input int h,
                            input int w, input logic [3:0] s);
    regWrite(5'h00, p);
    regWrite(5'h04, pt);
    regWrite(5'h08, {16'(h), 16'(w)});
    expPtr = p; expPitch = pt; expWords = w; expStrb = s;
    mLine = 0; mWord = 0;
  endtask

  task automatic finish();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChk, nBad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nBad++;
    $display("FAIL watchdog expired");
    finish();
  end

  typedef struct packed {
    logic [4:0]  a;
    logic [31:0] w;
    logic [31:0] e;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{a: 5'h00, w: 32'h1000_0003, e: 32'h1000_0000},
    '{a: 5'h04, w: 32'h0000_012F, e: 32'h0000_0120},
    '{a: 5'h08, w: 32'h0003_0010, e: 32'h0003_0010},
    '{a: 5'h0C, w: 32'h0020_0004, e: 32'h5460_0004},
    '{a: 5'h0C, w: 32'h000F_8000, e: 32'h544F_0000},
    '{a: 5'h10, w: 32'hFFFF_FFFF, e: 32'h0000_0000}
  };

  logic [31:0] rd;
  int guard;

  initial begin
    rstN = 1'b0; busWrEn = 1'b0; busAddr = '0; busWrData = '0;
    pixValid = 1'b0; pixData = '0; pixEol = 1'b0; memWrReady = 1'b1;
    repeat (5) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk); #2;

    // reset state
    regRead(5'h0C, rd); check("R2 reset ctrl", rd, 32'h5440_0000);
    regRead(5'h10, rd); check("R6 reset progress", rd, 32'h0);
    check("R9 reset irq", {31'd0, irq}, 32'h0);
    check("R8 reset no write", {31'd0, memWrValid}, 32'h0);

    // register vector walk
    foreach (VECS[i]) begin
      regWrite(VECS[i].a, VECS[i].w);
      regRead(VECS[i].a, rd);
      check((VECS[i].a == 5'h0C) ? "R2 ctrl readback" : "R1 reg readback", rd, VECS[i].e);
    end

    // frame 1: always ready, interrupt enabled
    readyMode = 0;
    setupFrame(32'h2000_0000, 32'h100, 3, 4, 4'hF);
    regWrite(5'h0C, 32'h000F_0005);
    #1;
    regRead(5'h0C, rd); check("R3 busy after go", {31'd0, rd[1]}, 32'h1);
    regRead(5'h10, rd); check("R6 progress cleared by go", rd, 32'h0);
    sendLines(0, 3, 4);
    @(negedge clk); #2;
    regRead(5'h0C, rd); check("R7 busy until cycle after commit", {31'd0, rd[1]}, 32'h1);
    regRead(5'h10, rd); check("R6 progress after frame", rd, 32'd3);
    check("R7 no pixel taken after last line", {31'd0, pixReady}, 32'h0);
    @(negedge clk); #2;
    regRead(5'h0C, rd); check("R7 busy cleared", {31'd0, rd[1]}, 32'h0);
    check("R9 irq raised", {31'd0, irq}, 32'h1);
    check("R4 write count frame1", wrCount, 32'd12);
    regWrite(5'h0C, 32'h000F_0000);
    #1;
    check("R9 irq acknowledged", {31'd0, irq}, 32'h0);

    // frame 2: stalls, go while busy, interrupt disabled
    readyMode = 1;
    setupFrame(32'h3000_0040, 32'h40, 2, 3, 4'h5);
    regWrite(5'h0C, 32'h0005_0001);
    sendLines(0, 1, 3);
    regWrite(5'h00, 32'h7000_0000);
    regWrite(5'h0C, 32'h0005_0001);
    repeat (3) @(negedge clk);
    #2;
    regRead(5'h10, rd); check("R3 go while busy ignored", rd, 32'd1);
    sendLines(1, 1, 3);
    guard = 0;
    do begin @(negedge clk); #2; regRead(5'h0C, rd); guard++; end while (rd[1] && guard < 50);
    check("R7 frame2 ends", {31'd0, rd[1]}, 32'h0);
    regRead(5'h10, rd); check("R6 progress frame2", rd, 32'd2);
    check("R9 irq masked", {31'd0, irq}, 32'h0);
    check("R3 latched pointer used", wrCount, 32'd18);

    // height zero
    readyMode = 0;
    setupFrame(32'h5000_0000, 32'h10, 0, 4, 4'hF);
    regWrite(5'h0C, 32'h000F_0005);
    #1;
    regRead(5'h0C, rd); check("R10 busy one cycle", {31'd0, rd[1]}, 32'h1);
    @(negedge clk); #2;
    regRead(5'h0C, rd); check("R10 busy cleared", {31'd0, rd[1]}, 32'h0);
    check("R10 irq", {31'd0, irq}, 32'h1);

    // abort with a stalled write
    readyMode = 2;
    setupFrame(32'h4000_0000, 32'h10, 4, 4, 4'hF);
    regWrite(5'h0C, 32'h000F_0005);
    check("R9 go clears ended state", {31'd0, irq}, 32'h0);
    @(negedge clk);
    pixValid = 1'b1; pixData = 32'hA500_0000; pixEol = 1'b0;
    @(negedge clk);
    pixValid = 1'b0;
    #2;
    check("R8 write pending before abort", {31'd0, memWrValid}, 32'h1);
    regWrite(5'h0C, 32'h000F_4004);
    #2;
    check("R8 write dropped", {31'd0, memWrValid}, 32'h0);
    regRead(5'h0C, rd); check("R8 busy cleared", {31'd0, rd[1]}, 32'h0);
    regRead(5'h10, rd); check("R8 progress kept", rd, 32'h0);
    check("R9 irq after abort", {31'd0, irq}, 32'h1);
    check("R8 no pixel after abort", {31'd0, pixReady}, 32'h0);

    finish();
  end
endmodule